// File: doc/BRIEF.md
# Reference Clock Frequency Monitor with Hysteresis

This block judges whether a reference clock runs at an acceptable frequency. It does this by counting the reference's rising edges over a long window. The window length is measured in system clock cycles and set through an input. When a window closes, the edge count is compared against two pairs of bounds. The outer pair is the failure bounds and the inner pair is the recovery bounds. The space between an inner bound and its outer neighbour is a dead band, and in that band the reported status does not move.

A status change must be earned. The block declares the reference bad only after two windows in a row both land outside the outer bounds. It declares the reference good again only after two windows in a row both land inside the inner bounds. Any window that does not agree with the previous one cancels the pending change. After reset the reference is reported failed, so it has to qualify before it is trusted. A mask input forces the reported status to good while the judgement underneath keeps running.

The reference input is expected to be already synchronised to the system clock. The switching policy that acts on the status sits outside this block.

Top module: `refclk_freq_mon`

## Requirements
- R1: While `rst_n` is low and `hold_good` is low, `ref_good` reads 0 and `win_done` reads 0.
- R2: `win_done` pulses high for exactly one cycle after every `win_cycles` clock edges, counted from the release of reset. The edge count of a window is the number of edges at which `ref_in` is sampled 1 after having been sampled 0. The sample before the first edge counts as 0.
- R3: A window whose count is below `lim_lo_out` or above `lim_hi_out` is a failing window. This check takes priority over the recovery check.
- R4: A window whose count is not failing, and lies within `lim_lo_in` to `lim_hi_in` inclusive, is a passing window.
- R5: A window that is neither failing nor passing leaves the status unchanged and cancels any pending change.
- R6: The status turns bad only when the current window and the previous window both fail. It turns good only when the current window and the previous window both pass. A change becomes visible in the cycle in which `win_done` is high.
- R7: After reset the status is bad, so two passing windows are needed before `ref_good` goes high.
- R8: While `hold_good` is high, `ref_good` reads 1. The window judgement continues underneath, so `ref_good` shows the updated status once the mask drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, already synchronised to `clk` |
| win_cycles | input | WIN_W | Window length in system clock cycles |
| lim_lo_out | input | CNT_W | Lower failure bound on the edge count |
| lim_lo_in | input | CNT_W | Lower recovery bound on the edge count |
| lim_hi_in | input | CNT_W | Upper recovery bound on the edge count |
| lim_hi_out | input | CNT_W | Upper failure bound on the edge count |
| hold_good | input | 1 | Mask: forces `ref_good` to 1 |
| ref_good | output | 1 | Reported reference status, 1 = good |
| win_done | output | 1 | One-cycle pulse when a window has been judged |

## Verification
Directed windows place an exact number of single-cycle pulses inside each window. They sit on every bound and one past it, such as counts 7, 8, 11, 12, 20, 21, 24 and 25 against bounds 8, 12, 20 and 24. These cases separate an off-by-one in a compare from a correct compare. Sequences of fail, pass and dead-band windows in different orders show whether a single window, or a pair broken by a dead-band window, can move the status. Masked phases show whether the judgement keeps running underneath the mask. Random edge counts per window, and fully random reference levels that straddle window boundaries, are compared each cycle against a bench model; a second window length exposes timer errors.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

    // Judgement of one window
    typedef enum logic [1:0] {
        VERD_DEAD = 2'd0,
        VERD_FAIL = 2'd1,
        VERD_PASS = 2'd2
    } verdict_e;

    // Change awaiting a confirming window
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_BAD  = 2'd1,
        PEND_GOOD = 2'd2
    } pend_e;

endpackage

// File: rtl/fmon_window.sv
module fmon_window #(
    parameter int WIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             tick
);
    localparam logic [WIN_W:0] STEP = {{WIN_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIN_W-1:0] elapsed;
    } state_t;

    state_t st_q, st_d;
    logic   last_cyc;

    always_comb begin
        st_d     = st_q;
        // a length of 0 or 1 closes a window every cycle
        last_cyc = ({1'b0, st_q.elapsed} + STEP) >= {1'b0, win_cycles};
        if (last_cyc) begin
            st_d.elapsed = '0;
        end else begin
            st_d.elapsed = st_q.elapsed + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = last_cyc;

endmodule

// File: rtl/fmon_edge_count.sv
module fmon_edge_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             tick,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t           st_q, st_d;
    logic             rise;
    logic [CNT_W-1:0] sum;

    always_comb begin
        st_d      = st_q;
        rise      = ref_in & ~st_q.prev;
        // saturate instead of wrapping so a fast reference still reads high
        if (rise && (st_q.cnt != CNT_MAX)) begin
            sum = st_q.cnt + 1'b1;
        end else begin
            sum = st_q.cnt;
        end
        st_d.prev = ref_in;
        st_d.cnt  = tick ? '0 : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // count including the edge seen in the closing cycle
    assign total = sum;

endmodule

// File: rtl/fmon_judge.sv
module fmon_judge
    import fmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] lim_lo_out,
    input  logic [CNT_W-1:0] lim_lo_in,
    input  logic [CNT_W-1:0] lim_hi_in,
    input  logic [CNT_W-1:0] lim_hi_out,
    output logic             good,
    output pend_e            pend,
    output logic             done
);
    typedef struct packed {
        logic  good;
        pend_e pend;
        logic  done;
    } state_t;

    state_t   st_q, st_d;
    verdict_e verd;

    always_comb begin
        if ((total < lim_lo_out) || (total > lim_hi_out)) begin
            verd = VERD_FAIL;
        end else if ((total >= lim_lo_in) && (total <= lim_hi_in)) begin
            verd = VERD_PASS;
        end else begin
            verd = VERD_DEAD;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = tick;
        if (tick) begin
            st_d.pend = PEND_NONE;
            if (verd == VERD_FAIL && st_q.good) begin
                if (st_q.pend == PEND_BAD) begin
                    st_d.good = 1'b0;
                end else begin
                    st_d.pend = PEND_BAD;
                end
            end else if (verd == VERD_PASS && !st_q.good) begin
                if (st_q.pend == PEND_GOOD) begin
                    st_d.good = 1'b1;
                end else begin
                    st_d.pend = PEND_GOOD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{good: 1'b0, pend: PEND_NONE, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign good = st_q.good;
    assign pend = st_q.pend;
    assign done = st_q.done;

endmodule

// File: rtl/refclk_freq_mon.sv
module refclk_freq_mon
    import fmon_pkg::*;
#(
    parameter int WIN_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [WIN_W-1:0] win_cycles,
    input  logic [CNT_W-1:0] lim_lo_out,
    input  logic [CNT_W-1:0] lim_lo_in,
    input  logic [CNT_W-1:0] lim_hi_in,
    input  logic [CNT_W-1:0] lim_hi_out,
    input  logic             hold_good,
    output logic             ref_good,
    output logic             win_done
);
    logic             tick;
    logic [CNT_W-1:0] total;
    logic             stat_good;
    pend_e            stat_pend;

    fmon_window #(.WIN_W(WIN_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_cycles (win_cycles),
        .tick       (tick)
    );

    fmon_edge_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .tick   (tick),
        .total  (total)
    );

    fmon_judge #(.CNT_W(CNT_W)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .total      (total),
        .lim_lo_out (lim_lo_out),
        .lim_lo_in  (lim_lo_in),
        .lim_hi_in  (lim_hi_in),
        .lim_hi_out (lim_hi_out),
        .good       (stat_good),
        .pend       (stat_pend),
        .done       (win_done)
    );

    assign ref_good = hold_good | stat_good;

endmodule

// File: rtl/fmon_chk.sv
module fmon_chk
    import fmon_pkg::*;
#(
    parameter int WIN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIN_W-1:0] win_cycles,
    input logic             win_done,
    input logic             stat_good,
    input pend_e            stat_pend
);
    // R1
    reset_bad_chk: assert property (@(posedge clk) !rst_n |=> !stat_good);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && win_cycles >= 2) |=> !win_done);

    // R6
    change_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_good) |-> win_done);

    // R6
    rise_confirmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_good) |-> $past(stat_pend) == PEND_GOOD);

    // R6
    fall_confirmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_good) |-> $past(stat_pend) == PEND_BAD);

    // R5
    pend_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_pend == PEND_GOOD) |-> !stat_good);

endmodule

bind refclk_freq_mon fmon_chk #(.WIN_W(WIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_cycles (win_cycles),
    .win_done   (win_done),
    .stat_good  (stat_good),
    .stat_pend  (stat_pend)
);

// File: tb/sim_refclk_freq_mon.sv
module sim_refclk_freq_mon;
    localparam int CLK_PERIOD = 10;
    localparam int WIN_W = 32;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_in = 1'b0;
    logic [WIN_W-1:0] win_cycles = 32'd64;
    logic [CNT_W-1:0] lim_lo_out = 16'd8;
    logic [CNT_W-1:0] lim_lo_in = 16'd12;
    logic [CNT_W-1:0] lim_hi_in = 16'd20;
    logic [CNT_W-1:0] lim_hi_out = 16'd24;
    logic             hold_good = 1'b0;
    logic             ref_good;
    logic             win_done;

    int    n_chk = 0;
    int    n_err = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // bench model state
    int m_prev, m_cnt, m_tmr, m_good, m_pend, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    refclk_freq_mon #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .win_cycles(win_cycles),
        .lim_lo_out(lim_lo_out), .lim_lo_in(lim_lo_in), .lim_hi_in(lim_hi_in),
        .lim_hi_out(lim_hi_out), .hold_good(hold_good),
        .ref_good(ref_good), .win_done(win_done)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // 1 fail, 2 pass, 0 dead band (R3, R4)
    function automatic int verdict(int c);
        if (c < int'(lim_lo_out) || c > int'(lim_hi_out)) return 1;
        if (c >= int'(lim_lo_in) && c <= int'(lim_hi_in)) return 2;
        return 0;
    endfunction

    // status update from the requirements (R5, R6)
    task automatic judge(int c);
        int v;
        v = verdict(c);
        if (v == 1 && m_good == 1) begin
            if (m_pend == 1) begin m_good = 0; m_pend = 0; end
            else m_pend = 1;
        end else if (v == 2 && m_good == 0) begin
            if (m_pend == 2) begin m_good = 1; m_pend = 0; end
            else m_pend = 2;
        end else begin
            m_pend = 0;
        end
    endtask

    task automatic do_reset(int w);
        @(negedge clk);
        rst_n = 1'b0;
        ref_in = 1'b0;
        hold_good = 1'b0;
        win_cycles = WIN_W'(w);
        m_prev = 0; m_cnt = 0; m_tmr = 0; m_good = 0; m_pend = 0; m_done = 0;
        @(negedge clk);
        check("R1", "ref_good in reset", int'(ref_good), 0);
        check("R1", "win_done in reset", int'(win_done), 0);
        rst_n = 1'b1;
    endtask

    // one cycle: drive at negedge, predict, check at next negedge
    task automatic step(bit v);
        int r;
        ref_in = v;
        r = (v && m_prev == 0) ? 1 : 0;
        m_prev = int'(v);
        if (m_tmr + 1 >= int'(win_cycles)) begin
            judge(m_cnt + r);
            m_cnt = 0;
            m_tmr = 0;
            m_done = 1;
        end else begin
            m_cnt = m_cnt + r;
            m_tmr = m_tmr + 1;
            m_done = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check("R2", "win_done", int'(win_done), m_done);
        check(cur_req, "ref_good", int'(ref_good), (hold_good ? 1 : m_good));
    endtask

    // one full window holding exactly n single-cycle pulses
    task automatic run_win(int n);
        for (int i = 0; i < int'(win_cycles); i++) begin
            step((i % 2 == 1) && (i / 2 < n));
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd20240611);
        do_reset(64);

        // R7: first passing window alone is not enough
        cur_req = "R7";
        run_win(16);
        check("R7", "after one pass", int'(ref_good), 0);
        run_win(16);
        check("R7", "after two passes", int'(ref_good), 1);

        // R3: lower failure bound edge
        cur_req = "R3";
        run_win(8);
        run_win(8);
        check("R3", "count at lo_out is not failing", int'(ref_good), 1);
        run_win(7);
        check("R3", "one failing window", int'(ref_good), 1);
        run_win(7);
        check("R3", "two failing windows", int'(ref_good), 0);

        // R4: recovery bounds inclusive
        cur_req = "R4";
        run_win(12);
        run_win(20);
        check("R4", "counts 12 and 20 pass", int'(ref_good), 1);
        cur_req = "R3";
        run_win(25);
        run_win(25);
        check("R3", "above hi_out", int'(ref_good), 0);

        // R5: dead band holds status and cancels a pending change
        cur_req = "R5";
        run_win(11);
        run_win(21);
        check("R5", "dead band keeps bad", int'(ref_good), 0);
        run_win(12);
        run_win(24);
        run_win(20);
        check("R5", "dead band breaks pass pair", int'(ref_good), 0);
        run_win(20);
        check("R5", "pass pair after dead band", int'(ref_good), 1);
        run_win(24);
        run_win(8);
        check("R5", "dead band keeps good", int'(ref_good), 1);

        // R6: alternating fail/pass never changes status
        cur_req = "R6";
        run_win(5);
        run_win(16);
        run_win(5);
        run_win(16);
        check("R6", "alternating windows", int'(ref_good), 1);
        run_win(30);
        run_win(3);
        check("R6", "fail high then low", int'(ref_good), 0);

        // R8: mask forces good, judgement continues
        cur_req = "R8";
        hold_good = 1'b1;
        run_win(2);
        check("R8", "masked output", int'(ref_good), 1);
        run_win(16);
        run_win(16);
        hold_good = 1'b0;
        step(1'b0);
        check("R8", "unmasked after passes", int'(ref_good), 1);
        do_reset(64);
        cur_req = "R8";
        run_win(16);
        run_win(16);
        hold_good = 1'b1;
        run_win(0);
        run_win(0);
        hold_good = 1'b0;
        step(1'b0);
        check("R8", "unmasked after fails", int'(ref_good), 0);

        // random edge counts per window
        cur_req = "R6";
        for (int k = 0; k < 150; k++) begin
            run_win($urandom_range(0, 31));
        end

        // R2: other window length with fully random reference levels
        do_reset(40);
        cur_req = "R2";
        for (int k = 0; k < 4000; k++) begin
            if (k % 97 == 0) hold_good = $urandom_range(0, 3) == 0;
            step(($urandom_range(0, 99) < 55) ? 1'b1 : 1'b0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule